// File: doc/BRIEF.md
# Switch Register Access Bridge

This block gives a host processor a window into the internal register space of an Ethernet switch. That space is addressed by an 8-bit page and an 8-bit register number. On the host side there is a small 32-bit register slave. Through it, software stages up to 64 bits of write data and issues an access with a command word that carries the page, the register number, a direction bit and a self-clearing go/busy flag. It then collects up to 64 bits of read data. On the switch side the bridge drives a request/acknowledge register bus whose data path is 64 bits wide.

Before software may issue a command, it must win the bus through a request/grant handshake in the control register. The bridge shares the switch bus with one other internal requester, and grants the host only while that requester is idle. A separate capture register latches one-cycle event pulses from thirteen sources: eight port link events, the switch PHY, the time-sync event and three sleep timers. Software clears these bits by writing ones. An enable bit gates their OR onto a host interrupt line.

Host reads are registered: `h_rdata` shows the register that `h_addr` selected one clock earlier.

Top module: `swreg_bridge`

## Requirements
- R1: After reset, every host-visible register reads 0 (except control bit 6, which mirrors `sw_init_done`), and `sw_req`, `alt_gnt` and `host_irq` are 0.
- R2: Setting control bit 3 (offset 0x40), while `alt_req` is low and `alt_gnt` is low, makes control bit 4 (grant) read 1. If `alt_req` is high, the grant stays 0.
- R3: A write to offset 0x2c with bit 0 set, while the host holds the grant and no access is active, raises `sw_req` on the next cycle. On that access, `sw_page` is bits 31:24, `sw_regnum` is bits 23:16 and `sw_we` is bit 1 (1 = write). Bit 0 of offset 0x2c reads 1 until the access ends.
- R4: `sw_req` stays high until a cycle in which `sw_ack` is high. On that edge, `sw_req` and the go bit clear together. For a read, offset 0x3c takes `sw_rdata[31:0]` and offset 0x38 takes `sw_rdata[63:32]` on the same edge.
- R5: `sw_wdata` is the word at offset 0x30 (upper half) joined to the word at offset 0x34 (lower half).
- R6: A command write while the host lacks the grant starts no access, and the go bit stays 0.
- R7: A command write while an access is active is ignored. The active access keeps its page and register fields, and no second access follows.
- R8: Once granted, the host keeps the grant while an access is active, even if bit 3 is cleared. The grant drops once bit 3 is 0 and no access is active.
- R9: `alt_gnt` rises one cycle after `alt_req` if the host holds no grant, and falls one cycle after `alt_req` drops. `alt_gnt` and the host grant are never both 1.
- R10: A high cycle on `irq_src[i]` sets bit i of offset 0x44. Writing 1 to a bit of offset 0x44 clears it. A pulse that arrives in the same cycle as a clear of that bit leaves the bit set.
- R11: `host_irq` is 1 exactly one cycle after control bit 1 is 1 and at least one bit of offset 0x44 is pending.
- R12: A write to offset 0x2c with bit 2 set aborts any active access: `sw_req` and the go bit are 0 on the next cycle, and no access is launched.
- R13: Control bit 6 reads the level of `sw_init_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_wr | input | 1 | Host write strobe |
| h_addr | input | 8 | Host byte offset |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Registered read data for the previous cycle's `h_addr` |
| sw_init_done | input | 1 | Switch initialisation finished |
| alt_req | input | 1 | Other requester wants the switch bus |
| alt_gnt | output | 1 | Other requester owns the switch bus |
| irq_src | input | 13 | Event pulses, one per source |
| host_irq | output | 1 | Gated interrupt to the host |
| sw_req | output | 1 | Switch access request |
| sw_we | output | 1 | 1 = write, 0 = read |
| sw_page | output | 8 | Switch page |
| sw_regnum | output | 8 | Switch register number |
| sw_wdata | output | 64 | Switch write data |
| sw_ack | input | 1 | Switch access complete |
| sw_rdata | input | 64 | Switch read data, valid with `sw_ack` |

## Verification
The bench runs the command path with a write access and a read access, using distinct page and register values. The write access separates the upper staged data word from the lower one. The read access separates the two read-return words and checks that they change on the same edge. It then issues commands under each refused condition: no grant, a command during an active access, and an abort during an access. Each refused case must leave the switch bus showing none of the refused command's effects. Finally, it tests arbitration against the other requester, and tests the interrupt capture with a single pulse, with a pulse that collides with its own clear, and with the enable off and on, which separates latching from gating.

// File: rtl/swbr_pkg.sv
package swbr_pkg;
  localparam logic [7:0] OFS_CMD = 8'h2c;
  localparam logic [7:0] OFS_WDH = 8'h30;
  localparam logic [7:0] OFS_WDL = 8'h34;
  localparam logic [7:0] OFS_RDH = 8'h38;
  localparam logic [7:0] OFS_RDL = 8'h3c;
  localparam logic [7:0] OFS_CTL = 8'h40;
  localparam logic [7:0] OFS_INT = 8'h44;
  // command word bit positions
  localparam int CB_GO   = 0;
  localparam int CB_WE   = 1;
  localparam int CB_ABRT = 2;
  localparam int CB_REG  = 16;
  localparam int CB_PAGE = 24;
  // control word bit positions
  localparam int CT_IEN  = 1;
  localparam int CT_REQ  = 3;
  localparam int CT_GNT  = 4;
  localparam int CT_INIT = 6;
endpackage

// File: rtl/swbr_arbiter.sv
module swbr_arbiter (
  input  logic clk,
  input  logic rst,
  input  logic host_req,
  input  logic busy,
  input  logic alt_req,
  output logic host_gnt,
  output logic alt_gnt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      host_gnt <= 1'b0;
      alt_gnt  <= 1'b0;
    end else begin
      if (host_gnt) begin
        if (!host_req && !busy) host_gnt <= 1'b0;
      end else if (host_req && !alt_req && !alt_gnt) begin
        host_gnt <= 1'b1;
      end
      if (alt_gnt) begin
        if (!alt_req) alt_gnt <= 1'b0;
      end else if (alt_req && !host_gnt) begin
        alt_gnt <= 1'b1;
      end
    end
  end

  assert_mutex_grant_R9: assert property (@(posedge clk) disable iff (rst)
    !(host_gnt && alt_gnt));
  assert_hold_in_flight_R8: assert property (@(posedge clk) disable iff (rst)
    (host_gnt && busy) |=> host_gnt);
endmodule

// File: rtl/swbr_irq_latch.sv
module swbr_irq_latch #(
  parameter int NSRC = 13
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src,
  input  logic            clr_wr,
  input  logic [NSRC-1:0] clr_mask,
  input  logic            ien,
  output logic [NSRC-1:0] pend,
  output logic            irq_o
);
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) pend[i] <= 1'b0;
      else     pend[i] <= src[i] | (pend[i] & ~(clr_wr & clr_mask[i]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= ien & (|pend);
  end

  assert_pulse_latched_R10: assert property (@(posedge clk) disable iff (rst)
    (|src) |=> ((pend & $past(src)) == $past(src)));
  assert_quiet_irq_R11: assert property (@(posedge clk) disable iff (rst)
    !$past(|pend) |-> !irq_o);
endmodule

// File: rtl/swbr_engine.sv
module swbr_engine #(
  parameter int PW = 8,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_wr,
  input  logic          cmd_go,
  input  logic          cmd_we,
  input  logic          cmd_abort,
  input  logic [PW-1:0] cmd_page,
  input  logic [PW-1:0] cmd_rn,
  input  logic          gnt_i,
  input  logic          ack_i,
  input  logic [DW-1:0] rdata_i,
  output logic          active_o,
  output logic          we_o,
  output logic [PW-1:0] page_o,
  output logic [PW-1:0] rn_o,
  output logic [DW-1:0] rdata_o
);
  logic launch, kill;
  assign kill   = cmd_wr && cmd_abort;
  assign launch = cmd_wr && cmd_go && !cmd_abort && gnt_i && !active_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_o <= 1'b0;
      we_o     <= 1'b0;
      page_o   <= '0;
      rn_o     <= '0;
      rdata_o  <= '0;
    end else if (kill) begin
      active_o <= 1'b0;
    end else if (launch) begin
      active_o <= 1'b1;
      we_o     <= cmd_we;
      page_o   <= cmd_page;
      rn_o     <= cmd_rn;
    end else if (active_o && ack_i) begin
      active_o <= 1'b0;
      if (!we_o) rdata_o <= rdata_i;
    end
  end

  assert_req_needs_grant_R3: assert property (@(posedge clk) disable iff (rst)
    active_o |-> gnt_i);
  assert_req_until_ack_R4: assert property (@(posedge clk) disable iff (rst)
    (active_o && !ack_i && !kill) |=> active_o);
  assert_abort_drops_R12: assert property (@(posedge clk) disable iff (rst)
    kill |=> !active_o);
endmodule

// File: rtl/swreg_bridge.sv
module swreg_bridge #(
  parameter int AW   = 8,
  parameter int HW   = 32,
  parameter int PW   = 8,
  parameter int NSRC = 13
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            h_wr,
  input  logic [AW-1:0]   h_addr,
  input  logic [HW-1:0]   h_wdata,
  output logic [HW-1:0]   h_rdata,
  input  logic            sw_init_done,
  input  logic            alt_req,
  output logic            alt_gnt,
  input  logic [NSRC-1:0] irq_src,
  output logic            host_irq,
  output logic            sw_req,
  output logic            sw_we,
  output logic [PW-1:0]   sw_page,
  output logic [PW-1:0]   sw_regnum,
  output logic [2*HW-1:0] sw_wdata,
  input  logic            sw_ack,
  input  logic [2*HW-1:0] sw_rdata
);
  import swbr_pkg::*;
  localparam int DW  = 2 * HW;
  localparam int CPAD = HW - 2*PW - 2;

  logic [HW-1:0] wd_lo, wd_hi;
  logic          ctl_ien, ctl_req, host_gnt;
  logic [NSRC-1:0] pend;
  logic [DW-1:0] rd_word;
  logic wr_cmd, wr_ctl, wr_int;

  assign wr_cmd = h_wr && (h_addr == AW'(OFS_CMD));
  assign wr_ctl = h_wr && (h_addr == AW'(OFS_CTL));
  assign wr_int = h_wr && (h_addr == AW'(OFS_INT));

  always_ff @(posedge clk) begin
    if (rst) begin
      wd_lo   <= '0;
      wd_hi   <= '0;
      ctl_ien <= 1'b0;
      ctl_req <= 1'b0;
    end else if (h_wr) begin
      if (h_addr == AW'(OFS_WDL)) wd_lo <= h_wdata;
      if (h_addr == AW'(OFS_WDH)) wd_hi <= h_wdata;
      if (wr_ctl) begin
        ctl_ien <= h_wdata[CT_IEN];
        ctl_req <= h_wdata[CT_REQ];
      end
    end
  end
  assign sw_wdata = {wd_hi, wd_lo};

  swbr_arbiter u_arb (
    .clk(clk), .rst(rst), .host_req(ctl_req), .busy(sw_req),
    .alt_req(alt_req), .host_gnt(host_gnt), .alt_gnt(alt_gnt)
  );

  swbr_engine #(.PW(PW), .DW(DW)) u_eng (
    .clk(clk), .rst(rst), .cmd_wr(wr_cmd),
    .cmd_go(h_wdata[CB_GO]), .cmd_we(h_wdata[CB_WE]), .cmd_abort(h_wdata[CB_ABRT]),
    .cmd_page(h_wdata[CB_PAGE +: PW]), .cmd_rn(h_wdata[CB_REG +: PW]),
    .gnt_i(host_gnt), .ack_i(sw_ack), .rdata_i(sw_rdata),
    .active_o(sw_req), .we_o(sw_we), .page_o(sw_page), .rn_o(sw_regnum),
    .rdata_o(rd_word)
  );

  swbr_irq_latch #(.NSRC(NSRC)) u_irq (
    .clk(clk), .rst(rst), .src(irq_src), .clr_wr(wr_int),
    .clr_mask(h_wdata[NSRC-1:0]), .ien(ctl_ien), .pend(pend), .irq_o(host_irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      h_rdata <= '0;
    end else begin
      h_rdata <= '0;
      case (h_addr)
        AW'(OFS_CMD): h_rdata <= {sw_page, sw_regnum, {CPAD{1'b0}}, sw_we, sw_req};
        AW'(OFS_WDL): h_rdata <= wd_lo;
        AW'(OFS_WDH): h_rdata <= wd_hi;
        AW'(OFS_RDL): h_rdata <= rd_word[HW-1:0];
        AW'(OFS_RDH): h_rdata <= rd_word[DW-1:HW];
        AW'(OFS_CTL): begin
          h_rdata[CT_IEN]  <= ctl_ien;
          h_rdata[CT_REQ]  <= ctl_req;
          h_rdata[CT_GNT]  <= host_gnt;
          h_rdata[CT_INIT] <= sw_init_done;
        end
        AW'(OFS_INT): h_rdata[NSRC-1:0] <= pend;
        default: h_rdata <= '0;
      endcase
    end
  end

  assert_refused_no_grant_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd && !host_gnt && !sw_req) |=> !sw_req);
  assert_busy_ignores_cmd_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd && sw_req && !sw_ack) |=> $stable(sw_page) && $stable(sw_regnum));
endmodule

// File: tb/swreg_bridge_tb.sv
module swreg_bridge_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic        we;
    logic [7:0]  page;
    logic [7:0]  rn;
    logic [63:0] wdata;
    logic [63:0] rdata;
  } item_t;

  logic clk = 1'b0, rst = 1'b1;
  logic h_wr = 1'b0;
  logic [7:0] h_addr = '0;
  logic [31:0] h_wdata = '0, h_rdata;
  logic sw_init_done = 1'b0, alt_req = 1'b0, alt_gnt;
  logic [12:0] irq_src = '0;
  logic host_irq, sw_req, sw_we, sw_ack = 1'b0;
  logic [7:0] sw_page, sw_regnum;
  logic [63:0] sw_wdata, sw_rdata = '0;

  int total = 0, bad = 0;
  bit hold_ack = 1'b0;
  item_t expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  swreg_bridge u_dut (
    .clk(clk), .rst(rst), .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .sw_init_done(sw_init_done), .alt_req(alt_req),
    .alt_gnt(alt_gnt), .irq_src(irq_src), .host_irq(host_irq), .sw_req(sw_req),
    .sw_we(sw_we), .sw_page(sw_page), .sw_regnum(sw_regnum), .sw_wdata(sw_wdata),
    .sw_ack(sw_ack), .sw_rdata(sw_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); h_wr = 1'b1; h_addr = a; h_wdata = d;
    @(negedge clk); h_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); h_addr = a;
    @(negedge clk); d = h_rdata;
  endtask

  task automatic wait_go_clear();
    logic [31:0] v;
    for (int i = 0; i < 50; i++) begin
      rd(8'h2c, v);
      if (!v[0]) break;
    end
  endtask

  task automatic wait_grant();
    logic [31:0] v;
    for (int i = 0; i < 50; i++) begin
      rd(8'h40, v);
      if (v[4]) break;
    end
  endtask

  // scoreboard monitor and switch model
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (sw_req && !sw_ack) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R7 unexpected access", {sw_page, sw_regnum}, 0);
          it.rdata = '0;
        end else begin
          it = expq.pop_front();
          chk(sw_we == it.we && sw_page == it.page && sw_regnum == it.rn,
              "R3 access fields", {sw_we, sw_page, sw_regnum}, {it.we, it.page, it.rn});
          if (it.we) chk(sw_wdata == it.wdata, "R5 write data", sw_wdata, it.wdata);
        end
        @(negedge clk);
        while (hold_ack) @(negedge clk);
        if (sw_req) begin
          sw_ack = 1'b1; sw_rdata = it.rdata;
          @(negedge clk);
          sw_ack = 1'b0;
          chk(!sw_req, "R4 req drops after ack", sw_req, 0);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    item_t it;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1
    chk(!sw_req && !alt_gnt && !host_irq, "R1 outputs", {sw_req, alt_gnt, host_irq}, 0);
    rd(8'h2c, v); chk(v == 0, "R1 cmd", v, 0);
    rd(8'h40, v); chk(v == 0, "R1 ctl", v, 0);
    rd(8'h44, v); chk(v == 0, "R1 intr", v, 0);
    // R13
    sw_init_done = 1'b1;
    rd(8'h40, v); chk(v[6], "R13 init done", v, 32'h40);
    // R6
    wr(8'h2c, 32'h1122_0001);
    chk(!sw_req, "R6 no grant no access", sw_req, 0);
    rd(8'h2c, v); chk(v[0] == 1'b0, "R6 go stays 0", v, 0);
    // R9 and R2
    @(negedge clk); alt_req = 1'b1;
    @(negedge clk); chk(alt_gnt, "R9 alt grant", alt_gnt, 1);
    wr(8'h40, 32'h8);
    repeat (2) @(negedge clk);
    rd(8'h40, v); chk(!v[4], "R2 no grant while alt busy", v, 0);
    @(negedge clk); alt_req = 1'b0;
    @(negedge clk); chk(!alt_gnt, "R9 alt release", alt_gnt, 0);
    wait_grant();
    rd(8'h40, v); chk(v[4], "R2 grant given", v, 32'h10);
    @(negedge clk); alt_req = 1'b1;
    repeat (2) @(negedge clk); chk(!alt_gnt, "R9 alt waits for host", alt_gnt, 0);
    alt_req = 1'b0;
    // R5 / R3 write access
    wr(8'h34, 32'hCAFE_0001);
    wr(8'h30, 32'h0000_BEEF);
    it.we = 1'b1; it.page = 8'h12; it.rn = 8'h34; it.wdata = 64'h0000_BEEF_CAFE_0001; it.rdata = '0;
    expq.push_back(it);
    hold_ack = 1'b1;
    wr(8'h2c, 32'h1234_0003);
    chk(sw_req, "R3 req raised", sw_req, 1);
    rd(8'h2c, v); chk(v == 32'h1234_0003, "R3 go reads 1", v, 32'h1234_0003);
    hold_ack = 1'b0;
    wait_go_clear();
    // R4 read access
    it.we = 1'b0; it.page = 8'hA5; it.rn = 8'h07; it.wdata = '0; it.rdata = 64'h0123_4567_89AB_CDEF;
    expq.push_back(it);
    wr(8'h2c, 32'hA507_0001);
    wait_go_clear();
    rd(8'h3c, v); chk(v == 32'h89AB_CDEF, "R4 read low", v, 32'h89AB_CDEF);
    rd(8'h38, v); chk(v == 32'h0123_4567, "R4 read high", v, 32'h0123_4567);
    // R7 command while busy
    it.page = 8'h33; it.rn = 8'h44; it.rdata = 64'h5;
    expq.push_back(it);
    hold_ack = 1'b1;
    wr(8'h2c, 32'h3344_0001);
    wr(8'h2c, 32'h7788_0003);
    rd(8'h2c, v); chk(v[31:16] == 16'h3344, "R7 fields kept", v, 32'h3344_0001);
    hold_ack = 1'b0;
    wait_go_clear();
    repeat (4) @(negedge clk);
    chk(!sw_req && expq.size() == 0, "R7 no second access", sw_req, 0);
    // R8 grant held in flight
    it.page = 8'h01; it.rn = 8'h02; it.rdata = 64'h0;
    expq.push_back(it);
    hold_ack = 1'b1;
    wr(8'h2c, 32'h0102_0001);
    wr(8'h40, 32'h0);
    repeat (2) @(negedge clk);
    rd(8'h40, v); chk(v[4], "R8 grant held", v, 32'h10);
    hold_ack = 1'b0;
    wait_go_clear();
    repeat (3) @(negedge clk);
    rd(8'h40, v); chk(!v[4], "R8 grant released", v, 0);
    // R12 abort
    wr(8'h40, 32'h8);
    wait_grant();
    it.page = 8'h09; it.rn = 8'h0A;
    expq.push_back(it);
    hold_ack = 1'b1;
    wr(8'h2c, 32'h090A_0001);
    wr(8'h2c, 32'h0000_0004);
    chk(!sw_req, "R12 abort drops req", sw_req, 0);
    rd(8'h2c, v); chk(!v[0], "R12 go cleared", v, 0);
    hold_ack = 1'b0;
    repeat (4) @(negedge clk);
    // R10 capture and clear
    @(negedge clk); irq_src = 13'h200;
    @(negedge clk); irq_src = '0;
    rd(8'h44, v); chk(v == 32'h200, "R10 latch bit 9", v, 32'h200);
    @(negedge clk); irq_src = 13'h008; h_wr = 1'b1; h_addr = 8'h44; h_wdata = 32'h208;
    @(negedge clk); irq_src = '0; h_wr = 1'b0;
    rd(8'h44, v); chk(v == 32'h008, "R10 pulse beats clear", v, 32'h008);
    // R11
    chk(!host_irq, "R11 gated off", host_irq, 0);
    wr(8'h40, 32'h2);
    @(negedge clk); chk(host_irq, "R11 enabled", host_irq, 1);
    wr(8'h44, 32'hFFFF_FFFF);
    @(negedge clk); chk(!host_irq, "R11 cleared", host_irq, 0);
    rd(8'h44, v); chk(v == 0, "R10 clear all", v, 0);
    chk(expq.size() == 0, "R3 all accesses seen", expq.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule